// File: doc/BRIEF.md
# Mailbox Transmit Register Unit

This unit is the sending half of an inter-processor mailbox with eight channels. A host on a simple 32-bit register bus loads a 64-bit message as two 32-bit words, selects a destination channel, and then writes a launch command. The unit copies the message into a holding slot for that channel and raises the channel's valid line toward the remote core. The message is released when the remote core acknowledges it.

A single status word gives three fields for each channel. A busy field shows that a message is waiting for acknowledgement. A delivered field shows that a message was acknowledged. An overflow field shows that a launch was refused because the channel was still busy. Software clears the delivered and overflow bits by writing a mask. One interrupt line reports three kinds of event: a blocked launch, an overflow and a delivery. Each kind has its own mask bit, and software acknowledges the interrupt with a write-1-to-clear.

Top module: `mbox_tx_regs`

## Requirements
- R1: After reset, msg_valid is all zero, irq is 0, the status word at 0x14 reads 0, the interrupt status at 0x18 reads 0 and the mask register at 0x1C reads 7.
- R2: The destination register at 0x0 (3 bits, zero-extended on read), the low word at 0x4 and the high word at 0x8 read back the last value written to them.
- R3: A write to 0xC with wdata bit 0 = 1, aimed at an idle channel c, raises msg_valid[c] on the next cycle. It presents {high word, low word} on msg_data[c*64 +: 64] and sets status bit c (busy field, bits 7:0). A write to 0xC with bit 0 = 0 changes nothing.
- R4: In a cycle where msg_valid[c] and msg_ack[c] are both high, msg_valid[c] drops and busy bit c clears on the next cycle, and status bit 16+c (delivered field, bits 23:16) sets.
- R5: A launch aimed at a busy channel c is dropped. The channel's held message and valid line are unchanged, and status bit 8+c (overflow field, bits 15:8) sets.
- R6: A write to 0x10 clears each delivered and overflow bit whose position (8..15, 16..23) holds a 1 in wdata. Busy bits and the other bits are left unchanged.
- R7: Mask bits at 0x1C are: bit 0 for the blocked-launch event, bit 1 for the overflow event and bit 2 for the delivered event. A 1 suppresses that event.
- R8: Interrupt status bit 0 (0x18) sets on any unmasked event, and irq equals that bit. An event whose mask bit is 1 does not set it.
- R9: Writing 0x18 with bit 0 = 1 clears the interrupt status, and writing 0 leaves it set. If an unmasked event occurs in the same cycle as the clear, the bit stays set.
- R10: Channels are independent. Several channels may be busy at once, and an acknowledge on one channel leaves the others' valid and status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| msg_valid | output | 8 | One line per channel: message waiting |
| msg_data | output | 512 | Held 64-bit message of each channel, channel c at [c*64 +: 64] |
| msg_ack | input | 8 | One line per channel: remote core accepts the message |
| irq | output | 1 | Interrupt request |

## Verification
The main send-and-acknowledge path is driven from a table of messages. The table covers the lowest and highest channel and data patterns with all bits set, alternating bits and walking values, so a wrong channel decode, swapped message halves or a stuck data bit shows up as a mismatch on msg_data. Directed sequences then launch at a busy channel to separate the drop-and-flag path from a normal launch. Other sequences change the three mask bits one at a time to show which event reaches irq. A clear that coincides with an acknowledge confirms that the set has priority, and a partial clear mask confirms that clearing works bit by bit.

// File: rtl/mbox_tx_regs.sv
module mbox_tx_regs #(
  parameter int NCH = 8,
  parameter int AW  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NCH-1:0]      msg_valid,
  output logic [NCH*64-1:0]   msg_data,
  input  logic [NCH-1:0]      msg_ack,
  output logic                irq
);
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IDW-1:0] dest_q;
  logic [31:0]    lo_q, hi_q;
  logic [NCH-1:0] busy_q, ovf_q, dlv_q;
  logic [2:0]     mask_q;
  logic           isr_q;

  wire wr_dest = wr_en && addr == AW'('h00);
  wire wr_lo   = wr_en && addr == AW'('h04);
  wire wr_hi   = wr_en && addr == AW'('h08);
  wire trig    = wr_en && addr == AW'('h0C) && wdata[0];
  wire wr_clr  = wr_en && addr == AW'('h10);
  wire wr_isr  = wr_en && addr == AW'('h18);
  wire wr_mask = wr_en && addr == AW'('h1C);

  wire [NCH-1:0] sel     = NCH'(1) << dest_q;
  wire           blocked = trig && busy_q[dest_q];
  wire           launch  = trig && !busy_q[dest_q];
  wire [NCH-1:0] done    = busy_q & msg_ack;
  wire [NCH-1:0] clr_ovf = wr_clr ? wdata[8 +: NCH]  : '0;
  wire [NCH-1:0] clr_dlv = wr_clr ? wdata[16 +: NCH] : '0;

  wire event_hit = (blocked && !mask_q[0]) || (blocked && !mask_q[1]) ||
                   ((|done) && !mask_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      busy_q <= '0;
      ovf_q  <= '0;
      dlv_q  <= '0;
      mask_q <= 3'b111;
      isr_q  <= 1'b0;
    end else begin
      if (wr_dest) dest_q <= wdata[IDW-1:0];
      if (wr_lo)   lo_q   <= wdata;
      if (wr_hi)   hi_q   <= wdata;
      if (wr_mask) mask_q <= wdata[2:0];
      busy_q <= (busy_q & ~done) | (launch ? sel : '0);
      ovf_q  <= (ovf_q & ~clr_ovf) | (blocked ? sel : '0);
      dlv_q  <= (dlv_q & ~clr_dlv) | done;
      isr_q  <= event_hit || (isr_q && !(wr_isr && wdata[0]));
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic [63:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                slot_q <= '0;
      else if (launch && sel[c]) slot_q <= {hi_q, lo_q};
    end
    assign msg_data[c*64 +: 64] = slot_q;

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid[c] && msg_ack[c]) |=> (!msg_valid[c] && rdata_dlv_bit(c)));

    // R3
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid[c]) |-> $past(trig && dest_q == IDW'(c)));

    // R5
    held_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid[c] && !msg_ack[c]) |=> (msg_valid[c] && $stable(msg_data[c*64 +: 64])));
  end

  function automatic logic rdata_dlv_bit(input int c);
    return dlv_q[c];
  endfunction

  logic [31:0] status;
  always_comb begin
    status = '0;
    status[0 +: NCH]  = busy_q;
    status[8 +: NCH]  = ovf_q;
    status[16 +: NCH] = dlv_q;
  end

  always_comb begin
    case (addr)
      AW'('h00): rdata = 32'(dest_q);
      AW'('h04): rdata = lo_q;
      AW'('h08): rdata = hi_q;
      AW'('h14): rdata = status;
      AW'('h18): rdata = {31'b0, isr_q};
      AW'('h1C): rdata = {29'b0, mask_q};
      default:   rdata = '0;
    endcase
  end

  assign msg_valid = busy_q;
  assign irq       = isr_q;

  // R5
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy_q[dest_q]) |=> (ovf_q[$past(dest_q)] && $stable(msg_valid)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 3'b111 && !irq) |=> !irq);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && wr_isr && wdata[0] && !event_hit) |=> !irq);
endmodule

// File: tb/mbox_tx_regs_tb_top.sv
module mbox_tx_regs_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] msg_valid, msg_ack = 0;
  logic [511:0] msg_data;
  logic irq;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mbox_tx_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_ack(msg_ack), .irq(irq));

  // {channel, high word, low word}
  localparam logic [66:0] VECS [5] = '{
    {3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd7, 32'hAAAA_AAAA, 32'h5555_5555},
    {3'd3, 32'h0000_0001, 32'h8000_0000},
    {3'd5, 32'h1234_5678, 32'h9ABC_DEF0},
    {3'd1, 32'h0000_0000, 32'hC3C3_3C3C}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ack(logic [7:0] m);
    @(negedge clk); msg_ack = m;
    @(negedge clk); msg_ack = 0;
  endtask

  task automatic send(int ch, logic [31:0] hi, logic [31:0] lo);
    wr(6'h04, lo); wr(6'h08, hi); wr(6'h00, ch); wr(6'h0C, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 valid", msg_valid, 0);
    check("R1 irq", irq, 0);
    rd(6'h14, r); check("R1 status", r, 0);
    rd(6'h18, r); check("R1 isr", r, 0);
    rd(6'h1C, r); check("R1 mask", r, 7);

    // R3 R4 table walk
    foreach (VECS[i]) begin
      int ch = VECS[i][66:64];
      send(ch, VECS[i][63:32], VECS[i][31:0]);
      check("R3 valid", msg_valid, 8'(1 << ch));
      check("R3 data", msg_data[ch*64 +: 64], VECS[i][63:0]);
      rd(6'h14, r); check("R3 busy", r, 32'(1 << ch));
      ack(8'(1 << ch));
      check("R4 valid", msg_valid, 0);
      rd(6'h14, r); check("R4 delivered", r, 32'(1 << (16 + ch)));
      wr(6'h10, 32'hFFFF_FFFF);
      rd(6'h14, r); check("R6 clear all", r, 0);
    end

    // R2
    wr(6'h00, 32'hFFFF_FFFE); rd(6'h00, r); check("R2 dest", r, 6);
    wr(6'h04, 32'hDEAD_BEEF); rd(6'h04, r); check("R2 lo", r, 32'hDEAD_BEEF);
    wr(6'h08, 32'hCAFE_F00D); rd(6'h08, r); check("R2 hi", r, 32'hCAFE_F00D);

    // R3 launch with bit0 = 0
    wr(6'h0C, 32'hFFFF_FFFE);
    check("R3 no launch", msg_valid, 0);

    // R5 and R8 masked: overflow with all masks set
    send(2, 32'h1111_1111, 32'h2222_2222);
    send(2, 32'h3333_3333, 32'h4444_4444);
    check("R5 data held", msg_data[2*64 +: 64], 64'h1111_1111_2222_2222);
    check("R5 valid", msg_valid, 8'h04);
    rd(6'h14, r); check("R5 overflow", r, 32'h0000_0404);
    check("R8 masked no irq", irq, 0);

    // R7 overflow event unmasked
    wr(6'h1C, 3'b101);
    wr(6'h0C, 1);
    check("R7 overflow irq", irq, 1);
    rd(6'h18, r); check("R8 isr", r, 1);
    wr(6'h18, 0); check("R9 write0 keeps", irq, 1);
    wr(6'h18, 1); check("R9 w1c", irq, 0);

    // R7 blocked event only
    wr(6'h1C, 3'b110);
    wr(6'h0C, 1);
    check("R7 blocked irq", irq, 1);
    wr(6'h18, 1);

    // R6 partial clear keeps busy
    wr(6'h10, 32'h0000_0004);
    rd(6'h14, r); check("R6 wrong bits", r, 32'h0000_0404);
    wr(6'h10, 32'h0000_04FF);
    rd(6'h14, r); check("R6 partial", r, 32'h0000_0004);

    // R7 delivered event; R9 set wins over clear
    wr(6'h1C, 3'b011);
    @(negedge clk); msg_ack = 8'h04; wr_en = 1; addr = 6'h18; wdata = 1;
    @(negedge clk); msg_ack = 0; wr_en = 0;
    check("R9 set wins", irq, 1);
    check("R7 delivered irq", irq, 1);
    wr(6'h18, 1);
    wr(6'h10, 32'hFFFF_FFFF);

    // R10 independence
    wr(6'h1C, 7);
    send(5, 32'h5, 32'h55);
    send(6, 32'h6, 32'h66);
    check("R10 both busy", msg_valid, 8'h60);
    ack(8'h20);
    check("R10 other kept", msg_valid, 8'h40);
    check("R10 data kept", msg_data[6*64 +: 64], 64'h0000_0006_0000_0066);
    rd(6'h14, r); check("R10 status", r, 32'h0020_0040);
    check("R8 masked deliver", irq, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule